// File: doc/BRIEF.md
# Output Driver Soft-Start Ramp Sequencer

This block spreads the power-up of an audio output driver over a programmed charge time, so that the driver does not produce a pop. The driver is requested whenever any of three audio sources is active: the converter path, the analog mix path or the click tone generator. While the request is held, the block raises an 8-bit level code in single steps from zero to full scale. An external driver/bias stage consumes this code. When the code reaches full scale the block reports that the driver has settled. When the request is removed, the code falls back to zero at the same rate.

The time to cover the whole ramp depends on two inputs taken together. The first is a duration select bit. The second is a flag saying that a virtual-ground amplifier is in use, which removes the output coupling capacitor. With no virtual ground the ramp lasts 0.8 s or 4 s. With virtual ground it lasts 1 ms or 5 ms. Time is counted on a tick input. The parameter `TICKS_PER_MS` gives the number of tick pulses that make one millisecond, so a simulation can shorten every duration. Suppression is active out of reset. Setting the bypass bit makes the code snap to its end value.

Top module: `drv_softstart`

## Requirements
- R1: After reset, ramp_o is 0 and both busy_o and done_o are 0.
- R2: The driver request is the OR of dac_en_i, mix_en_i and click_en_i. Any single one of them, held high, starts an upward ramp.
- R3: While ramping with bypass off, ramp_o changes by exactly one per step. Between steps it holds its value. A step occurs after N tick pulses, where N = max(1, floor(D * TICKS_PER_MS / 256)) and D is the selected duration in ms.
- R4: D is chosen as follows. With vgnd_on_i = 0, long_sel_i = 0 gives 800 and long_sel_i = 1 gives 4000. With vgnd_on_i = 1, long_sel_i = 0 gives 1 and long_sel_i = 1 gives 5.
- R5: done_o is 1 exactly when the request is high and ramp_o is 255. busy_o is 1 whenever ramp_o has not reached its target (255 if requested, otherwise 0). busy_o and done_o are never both 1.
- R6: When the request falls, done_o drops in the same cycle. ramp_o then steps down to 0 at the rate of R3, and busy_o clears at 0.
- R7: With ss_bypass_i = 1, ramp_o jumps to 255 on the first clock edge that sees the request high, and to 0 on the first edge that sees it low. Out of reset, with ss_bypass_i = 0, ramping is gradual.
- R8: A change of long_sel_i or vgnd_on_i during a ramp does not restart the ramp. ramp_o keeps its value, and the next step uses the new interval.
- R9: A request that returns during a downward ramp reverses direction from the current code, not from 0.
- R10: Steps are counted only on cycles where tick_i is 1. With tick_i held at 0, ramp_o does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse, TICKS_PER_MS per millisecond |
| dac_en_i | input | 1 | Converter path active |
| mix_en_i | input | 1 | Analog mix path active |
| click_en_i | input | 1 | Click tone source active |
| ss_bypass_i | input | 1 | 1 disables gradual ramping |
| long_sel_i | input | 1 | Duration select: 1 picks the longer time |
| vgnd_on_i | input | 1 | Virtual-ground amplifier in use |
| ramp_o | output | 8 | Driver level code, 0 to 255 |
| busy_o | output | 1 | Code is moving toward its target |
| done_o | output | 1 | Driver settled at full scale |

## Verification
On every cycle, the assertions check the single-step movement of the code and its stillness between steps. They also check the exclusivity and meaning of busy and done, that no step is taken once the target is reached, and the snap to full scale in bypass. Only the bench scenarios can show the absolute step timing for each select/virtual-ground combination. The same holds for the continuation of a ramp across a select change, the reversal from an intermediate code, and the halt of the ramp with no ticks.

// File: rtl/drv_softstart_pkg.sv
package drv_softstart_pkg;
  localparam int RAMP_W   = 8;
  localparam int DUR_SHORT_VG = 1;
  localparam int DUR_LONG_VG  = 5;
  localparam int DUR_SHORT_CAP = 800;
  localparam int DUR_LONG_CAP  = 4000;

  // ticks per code step for a duration in ms, never below one
  function automatic int step_ticks(input int dur_ms, input int tpm);
    int t;
    t = (dur_ms * tpm) / (1 << RAMP_W);
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int pick_dur(input logic long_sel, input logic vgnd);
    if (vgnd) return long_sel ? DUR_LONG_VG : DUR_SHORT_VG;
    return long_sel ? DUR_LONG_CAP : DUR_SHORT_CAP;
  endfunction
endpackage

// File: rtl/ss_interval_sel.sv
module ss_interval_sel
  import drv_softstart_pkg::*;
#(
  parameter int TICKS_PER_MS = 256,
  parameter int CW = 12
) (
  input  logic          long_sel_i,
  input  logic          vgnd_on_i,
  output logic [CW-1:0] interval_o
);
  always_comb begin
    interval_o = CW'(step_ticks(pick_dur(long_sel_i, vgnd_on_i), TICKS_PER_MS));
  end
endmodule

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [CW-1:0] interval_i,
  output logic          step_o
);
  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = (cnt_q >= interval_i - CW'(1));
  assign step_o    = run_i && tick_i && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_i) begin
      if (last_tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/ss_ramp_reg.sv
module ss_ramp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_i,
  input  logic         bypass_i,
  input  logic         step_i,
  output logic [W-1:0] ramp_o
);
  localparam logic [W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ramp_o <= '0;
    else if (bypass_i) ramp_o <= up_i ? FULL : '0;
    else if (step_i)   ramp_o <= up_i ? ramp_o + W'(1) : ramp_o - W'(1);
  end
endmodule

// File: rtl/drv_softstart.sv
module drv_softstart
  import drv_softstart_pkg::*;
#(
  parameter int TICKS_PER_MS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dac_en_i,
  input  logic              mix_en_i,
  input  logic              click_en_i,
  input  logic              ss_bypass_i,
  input  logic              long_sel_i,
  input  logic              vgnd_on_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_STEP = step_ticks(DUR_LONG_CAP, TICKS_PER_MS);
  localparam int CW       = $clog2(MAX_STEP + 1);
  localparam logic [RAMP_W-1:0] FULL = '1;

  // named internal events for the checker
  logic          req_any;
  logic          at_target;
  logic          run;
  logic          step_evt;
  logic [CW-1:0] interval;

  assign req_any   = dac_en_i | mix_en_i | click_en_i;
  assign at_target = req_any ? (ramp_o == FULL) : (ramp_o == '0);
  assign run       = !at_target && !ss_bypass_i;

  ss_interval_sel #(.TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) u_isel (
    .long_sel_i (long_sel_i),
    .vgnd_on_i  (vgnd_on_i),
    .interval_o (interval)
  );

  ss_step_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .run_i      (run),
    .interval_i (interval),
    .step_o     (step_evt)
  );

  ss_ramp_reg #(.W(RAMP_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_i     (req_any),
    .bypass_i (ss_bypass_i),
    .step_i   (step_evt),
    .ramp_o   (ramp_o)
  );

  assign busy_o = !at_target;
  assign done_o = req_any && (ramp_o == FULL);
endmodule

// File: rtl/drv_softstart_chk.sv
module drv_softstart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ss_bypass_i,
  input logic       req_any,
  input logic       at_target,
  input logic       step_evt,
  input logic [7:0] ramp_o,
  input logic       busy_o,
  input logic       done_o
);
  AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && req_any && !ss_bypass_i) |=> (ramp_o == $past(ramp_o) + 8'd1)); // R3
  AST_STEP_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !req_any && !ss_bypass_i) |=> (ramp_o == $past(ramp_o) - 8'd1)); // R6
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_bypass_i && !step_evt) |=> $stable(ramp_o)); // R3
  AST_NO_OVERSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> !at_target); // R3
  AST_DONE_MEANING: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (req_any && ramp_o == 8'hFF)); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R5
  AST_BYPASS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_bypass_i && req_any) |=> (ramp_o == 8'hFF)); // R7
endmodule

bind drv_softstart drv_softstart_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ss_bypass_i (ss_bypass_i),
  .req_any     (req_any),
  .at_target   (at_target),
  .step_evt    (step_evt),
  .ramp_o      (ramp_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/drv_softstart_bench.sv
`timescale 1ns/1ps
module drv_softstart_bench;
  localparam int TPM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic dac_en_i = 1'b0, mix_en_i = 1'b0, click_en_i = 1'b0;
  logic ss_bypass_i = 1'b0, long_sel_i = 1'b0, vgnd_on_i = 1'b0;
  logic [7:0] ramp_o;
  logic busy_o, done_o;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  drv_softstart #(.TICKS_PER_MS(TPM)) u_drv_softstart (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .dac_en_i(dac_en_i), .mix_en_i(mix_en_i), .click_en_i(click_en_i),
    .ss_bypass_i(ss_bypass_i), .long_sel_i(long_sel_i), .vgnd_on_i(vgnd_on_i),
    .ramp_o(ramp_o), .busy_o(busy_o), .done_o(done_o)
  );

  // interval in ticks, restated from R3/R4
  function automatic int ticks_for(input bit lsel, input bit vg);
    int ms;
    int n;
    case ({vg, lsel})
      2'b00: ms = 800;
      2'b01: ms = 4000;
      2'b10: ms = 1;
      default: ms = 5;
    endcase
    n = ms * TPM / 256;
    if (n == 0) n = 1;
    return n;
  endfunction

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 ramp", ramp_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_fast_up_down;
    int n;
    vgnd_on_i = 1'b1; long_sel_i = 1'b0;
    n = ticks_for(1'b0, 1'b1);
    mix_en_i = 1'b1;
    adv(100 * n);
    chk("R2 mix alone ramps", ramp_o, 100);
    chk("R5 busy mid ramp", busy_o, 1);
    adv(155 * n);
    chk("R4 vgnd short reaches full", ramp_o, 255);
    chk("R5 done at full", done_o, 1);
    chk("R5 busy clear at full", busy_o, 0);
    adv(10);
    chk("R3 holds at full", ramp_o, 255);
    mix_en_i = 1'b0;
    #1;
    chk("R6 done drops at once", done_o, 0);
    chk("R6 busy on ramp down", busy_o, 1);
    adv(255 * n);
    chk("R6 back to zero", ramp_o, 0);
    chk("R6 busy clear at zero", busy_o, 0);
  endtask

  task automatic t_slow_sel_reverse;
    int n0;
    int n1;
    vgnd_on_i = 1'b0; long_sel_i = 1'b0;
    n0 = ticks_for(1'b0, 1'b0);
    n1 = ticks_for(1'b1, 1'b0);
    click_en_i = 1'b1;
    adv(10 * n0 - 1);
    chk("R3 no step before interval", ramp_o, 9);
    adv(1);
    chk("R4 800ms interval step", ramp_o, 10);
    long_sel_i = 1'b1;
    adv(n1 - 1);
    chk("R8 no restart, new interval pending", ramp_o, 10);
    adv(1);
    chk("R8 step on new interval", ramp_o, 11);
    click_en_i = 1'b0;
    adv(n1);
    chk("R6 slow step down", ramp_o, 10);
    dac_en_i = 1'b1;
    adv(n1);
    chk("R9 reverse from current code", ramp_o, 11);
  endtask

  task automatic t_bypass;
    ss_bypass_i = 1'b1;
    adv(1);
    chk("R7 bypass jump full", ramp_o, 255);
    chk("R7 bypass done", done_o, 1);
    dac_en_i = 1'b0;
    adv(1);
    chk("R7 bypass jump zero", ramp_o, 0);
    chk("R7 bypass busy clear", busy_o, 0);
    ss_bypass_i = 1'b0;
  endtask

  task automatic t_no_tick;
    vgnd_on_i = 1'b1; long_sel_i = 1'b0;
    tick_i = 1'b0;
    dac_en_i = 1'b1;
    adv(20);
    chk("R10 frozen without tick", ramp_o, 0);
    chk("R10 busy while frozen", busy_o, 1);
    tick_i = 1'b1;
    adv(5);
    chk("R10 moves with ticks", ramp_o, 5);
    dac_en_i = 1'b0;
    adv(10);
    chk("R6 down after no-tick test", ramp_o, 0);
  endtask

  initial begin
    #200_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    adv(3);
    t_reset();
    rst_n = 1'b1;
    adv(2);
    t_reset();
    t_fast_up_down();
    t_slow_sel_reverse();
    t_bypass();
    t_no_tick();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule